// File: doc/BRIEF.md
# Linked-Load Reservation and Locked-Line Monitor

This block sits beside a data cache port and watches the stream of completed memory operations. It keeps a single reservation, made of a line address and the ID of the requester that made it. It uses that reservation to decide the outcome of every conditional store. A conditional store reports its outcome as a data value, 1 for success and 0 for failure, one cycle after it completes.

The block also tracks lines held by locked read-modify-write pairs. A completed locked read puts its line into a small table of blocked lines. The paired locked write takes it out again. While a line is in the table, any new request to that line is held back with a combinational stall. Requests to other lines pass through. Cache storage and coherence actions are outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: A completion with op code 4 (linked load) sets the reservation to its line and requester ID, replacing any earlier reservation.
- R2: One cycle after a completion with op code 5 (conditional store), sc_done_o is 1. In that same cycle, sc_data_o is 1 if the reservation was valid and its line and ID both match the store, and 0 otherwise. In every other cycle, both outputs are 0.
- R3: A conditional store whose line matches a valid reservation clears that reservation, whatever its outcome. A conditional store to a different line leaves the reservation unchanged.
- R4: A write-class completion (op code 3 store, 6 locked read, 7 locked write) with cmp_present_i=1, whose line and ID both match the valid reservation, clears it. If the ID differs, or cmp_present_i=0, the reservation stays.
- R5: Op codes 0 (none), 1 (load) and 2 (instruction fetch) leave the reservation unchanged, as does any cycle with cmp_valid_i=0.
- R6: A locked read (op code 6) places its line in the lowest-index free lock slot, and lock_busy_o bit k shows slot k in use. A line that is already blocked takes no second slot. When all slots are in use, the line is not recorded.
- R7: A locked write (op code 7) to a blocked line frees that line's slot from the next cycle.
- R8: req_stall_o is 1 in the same cycle exactly when req_valid_i is 1 and req_line_i is a blocked line.
- R9: After reset, the reservation is invalid with line and ID at 0, no lock slot is busy, and sc_done_o and sc_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmp_valid_i | input | 1 | A completion is presented this cycle |
| cmp_op_i | input | 3 | Completion op code (0 to 7, see requirements) |
| cmp_line_i | input | LINE_W | Line address of the completion |
| cmp_id_i | input | ID_W | Requester ID of the completion |
| cmp_present_i | input | 1 | The completing line is present in the cache |
| req_valid_i | input | 1 | A new request is offered to the queue |
| req_line_i | input | LINE_W | Line address of the new request |
| req_stall_o | output | 1 | Hold off the new request: its line is blocked |
| sc_done_o | output | 1 | A conditional-store result is presented |
| sc_data_o | output | 1 | Conditional-store result value (1 success, 0 failure) |
| resv_valid_o | output | 1 | The reservation is valid |
| resv_line_o | output | LINE_W | Reserved line address |
| resv_id_o | output | ID_W | Requester ID holding the reservation |
| lock_busy_o | output | LOCK_SLOTS | Per-slot busy flags of the blocked-line table |

## Verification
The bench aims at conditional stores that match on only one of line or ID. A design that checks only the line would report success to a foreign requester. A design that clears only on success would leave a stale reservation behind. It also sends plain stores from another requester and stores to absent lines, which a design with a loose clear condition would use to drop the reservation. On the lock side, it repeats a locked read to a line that is already blocked and sends one to a full table, where a design that is wrong would take a second slot or overwrite a slot. It then checks that the stall tracks only the blocked lines and is released on the cycle after the unblock.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_LOAD      = 3'd1,
      OP_IFETCH    = 3'd2,
      OP_STORE     = 3'd3,
      OP_LINKED_LD = 3'd4,
      OP_COND_ST   = 3'd5,
      OP_LOCK_RD   = 3'd6,
      OP_LOCK_WR   = 3'd7
   } llsc_op_e;

   function automatic logic op_is_write_class(llsc_op_e op);
      return (op == OP_STORE) || (op == OP_LOCK_RD) || (op == OP_LOCK_WR);
   endfunction
endpackage

// File: rtl/llsc_resv.sv
module llsc_resv
   import llsc_pkg::*;
#(
   parameter int LINE_W = 26,
   parameter int ID_W   = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmp_valid_i,
   input  llsc_op_e          cmp_op_i,
   input  logic [LINE_W-1:0] cmp_line_i,
   input  logic [ID_W-1:0]   cmp_id_i,
   input  logic              cmp_present_i,
   output logic              sc_pass_o,
   output logic              resv_valid_o,
   output logic [LINE_W-1:0] resv_line_o,
   output logic [ID_W-1:0]   resv_id_o
);
   logic              valid_q;
   logic [LINE_W-1:0] line_q;
   logic [ID_W-1:0]   id_q;
   logic              line_hit;
   logic              owner_hit;
   logic              is_ll;
   logic              is_sc;
   logic              is_wr;

   assign line_hit  = valid_q && (line_q == cmp_line_i);
   assign owner_hit = line_hit && (id_q == cmp_id_i);
   assign is_ll     = cmp_valid_i && (cmp_op_i == OP_LINKED_LD);
   assign is_sc     = cmp_valid_i && (cmp_op_i == OP_COND_ST);
   assign is_wr     = cmp_valid_i && op_is_write_class(cmp_op_i);
   assign sc_pass_o = is_sc && owner_hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         line_q  <= '0;
         id_q    <= '0;
      end else if (is_ll) begin
         valid_q <= 1'b1;
         line_q  <= cmp_line_i;
         id_q    <= cmp_id_i;
      end else if (is_sc && line_hit) begin
         valid_q <= 1'b0;
      end else if (is_wr && cmp_present_i && owner_hit) begin
         valid_q <= 1'b0;
      end
   end

   assign resv_valid_o = valid_q;
   assign resv_line_o  = line_q;
   assign resv_id_o    = id_q;

   AST_LL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_ll |=> valid_q && (line_q == $past(cmp_line_i)) && (id_q == $past(cmp_id_i))); // R1
   AST_SC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_sc && valid_q && (line_q == cmp_line_i)) |=> !valid_q); // R3
   AST_READS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmp_valid_i || cmp_op_i == OP_LOAD || cmp_op_i == OP_IFETCH || cmp_op_i == OP_NONE)
      |=> $stable(valid_q) && $stable(line_q) && $stable(id_q)); // R5
   AST_FOREIGN_WR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_valid_i && cmp_op_i == OP_STORE && cmp_id_i != id_q) |=> $stable(valid_q)); // R4
endmodule

// File: rtl/llsc_lock_slot.sv
module llsc_lock_slot #(
   parameter int LINE_W = 26
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              set_i,
   input  logic              unlock_i,
   input  logic [LINE_W-1:0] cmp_line_i,
   input  logic [LINE_W-1:0] req_line_i,
   output logic              busy_o,
   output logic              cmp_hit_o,
   output logic              req_hit_o
);
   logic              busy_q;
   logic [LINE_W-1:0] line_q;

   assign cmp_hit_o = busy_q && (line_q == cmp_line_i);
   assign req_hit_o = busy_q && (line_q == req_line_i);
   assign busy_o    = busy_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         line_q <= '0;
      end else if (set_i) begin
         busy_q <= 1'b1;
         line_q <= cmp_line_i;
      end else if (unlock_i && cmp_hit_o) begin
         busy_q <= 1'b0;
      end
   end

   AST_SLOT_TAKES_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> busy_q && (line_q == $past(cmp_line_i))); // R6
   AST_SLOT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unlock_i && busy_q && (line_q == cmp_line_i)) |=> !busy_q); // R7
endmodule

// File: rtl/llsc_lock_table.sv
module llsc_lock_table #(
   parameter int LINE_W     = 26,
   parameter int LOCK_SLOTS = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  lock_i,
   input  logic                  unlock_i,
   input  logic [LINE_W-1:0]     cmp_line_i,
   input  logic                  req_valid_i,
   input  logic [LINE_W-1:0]     req_line_i,
   output logic                  req_stall_o,
   output logic [LOCK_SLOTS-1:0] busy_o
);
   logic [LOCK_SLOTS-1:0] busy;
   logic [LOCK_SLOTS-1:0] cmp_hit;
   logic [LOCK_SLOTS-1:0] req_hit;
   logic [LOCK_SLOTS-1:0] first_free;
   logic [LOCK_SLOTS-1:0] set_vec;
   logic                  already;

   assign already = |cmp_hit;

   if (LOCK_SLOTS == 1) begin : g_single
      assign first_free = ~busy;
   end else begin : g_chain
      logic [LOCK_SLOTS:0] taken_below;
      assign taken_below[0] = 1'b0;
      for (genvar k = 0; k < LOCK_SLOTS; k++) begin : g_pick
         assign first_free[k]    = !busy[k] && !taken_below[k];
         assign taken_below[k+1] = taken_below[k] || !busy[k];
      end
   end

   assign set_vec = (lock_i && !already) ? first_free : '0;

   for (genvar k = 0; k < LOCK_SLOTS; k++) begin : g_slot
      llsc_lock_slot #(.LINE_W(LINE_W)) u_slot (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .set_i      (set_vec[k]),
         .unlock_i   (unlock_i),
         .cmp_line_i (cmp_line_i),
         .req_line_i (req_line_i),
         .busy_o     (busy[k]),
         .cmp_hit_o  (cmp_hit[k]),
         .req_hit_o  (req_hit[k])
      );
   end

   assign req_stall_o = req_valid_i && (|req_hit);
   assign busy_o      = busy;

   AST_ONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(set_vec)); // R6
   AST_NO_DUP_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(req_hit) <= 1); // R8
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int LINE_W     = 26,
   parameter int ID_W       = 4,
   parameter int LOCK_SLOTS = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cmp_valid_i,
   input  logic [2:0]            cmp_op_i,
   input  logic [LINE_W-1:0]     cmp_line_i,
   input  logic [ID_W-1:0]       cmp_id_i,
   input  logic                  cmp_present_i,
   input  logic                  req_valid_i,
   input  logic [LINE_W-1:0]     req_line_i,
   output logic                  req_stall_o,
   output logic                  sc_done_o,
   output logic                  sc_data_o,
   output logic                  resv_valid_o,
   output logic [LINE_W-1:0]     resv_line_o,
   output logic [ID_W-1:0]       resv_id_o,
   output logic [LOCK_SLOTS-1:0] lock_busy_o
);
   if (LINE_W < 1) begin : g_bad_line
      $error("LINE_W must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end
   if (LOCK_SLOTS < 1 || LOCK_SLOTS > 64) begin : g_bad_slots
      $error("LOCK_SLOTS must be between 1 and 64");
   end

   llsc_op_e op;
   logic     sc_pass;
   logic     is_sc;
   logic     done_q;
   logic     data_q;

   assign op    = llsc_op_e'(cmp_op_i);
   assign is_sc = cmp_valid_i && (op == OP_COND_ST);

   llsc_resv #(.LINE_W(LINE_W), .ID_W(ID_W)) u_resv (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cmp_valid_i   (cmp_valid_i),
      .cmp_op_i      (op),
      .cmp_line_i    (cmp_line_i),
      .cmp_id_i      (cmp_id_i),
      .cmp_present_i (cmp_present_i),
      .sc_pass_o     (sc_pass),
      .resv_valid_o  (resv_valid_o),
      .resv_line_o   (resv_line_o),
      .resv_id_o     (resv_id_o)
   );

   llsc_lock_table #(.LINE_W(LINE_W), .LOCK_SLOTS(LOCK_SLOTS)) u_locks (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lock_i      (cmp_valid_i && (op == OP_LOCK_RD)),
      .unlock_i    (cmp_valid_i && (op == OP_LOCK_WR)),
      .cmp_line_i  (cmp_line_i),
      .req_valid_i (req_valid_i),
      .req_line_i  (req_line_i),
      .req_stall_o (req_stall_o),
      .busy_o      (lock_busy_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         data_q <= 1'b0;
      end else begin
         done_q <= is_sc;
         data_q <= sc_pass;
      end
   end

   assign sc_done_o = done_q;
   assign sc_data_o = data_q;

   AST_SC_WIN_NEEDS_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_sc && !(resv_valid_o && resv_line_o == cmp_line_i && resv_id_o == cmp_id_i))
      |=> sc_done_o && !sc_data_o); // R2
   AST_NO_SC_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_sc |=> !sc_done_o && !sc_data_o); // R2
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
   localparam int LW = 26;
   localparam int IW = 4;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_valid = 1'b0;
   logic [2:0]    cmp_op = 3'd0;
   logic [LW-1:0] cmp_line = '0;
   logic [IW-1:0] cmp_id = '0;
   logic          cmp_present = 1'b0;
   logic          req_valid = 1'b0;
   logic [LW-1:0] req_line = '0;
   logic          req_stall, sc_done, sc_data, resv_valid;
   logic [LW-1:0] resv_line;
   logic [IW-1:0] resv_id;
   logic [NS-1:0] lock_busy;

   int tests = 0;
   int fails = 0;

   // reference state
   int m_rv = 0, m_rl = 0, m_ri = 0;
   int m_done = 0, m_data = 0;
   int m_busy[NS];
   int m_sl[NS];

   always #5 clk = ~clk;

   llsc_monitor #(.LINE_W(LW), .ID_W(IW), .LOCK_SLOTS(NS)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(cmp_valid), .cmp_op_i(cmp_op),
      .cmp_line_i(cmp_line), .cmp_id_i(cmp_id), .cmp_present_i(cmp_present),
      .req_valid_i(req_valid), .req_line_i(req_line), .req_stall_o(req_stall),
      .sc_done_o(sc_done), .sc_data_o(sc_data), .resv_valid_o(resv_valid),
      .resv_line_o(resv_line), .resv_id_o(resv_id), .lock_busy_o(lock_busy));

   task automatic check(input string tag, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int m_mask();
      int m = 0;
      for (int k = 0; k < NS; k++) if (m_busy[k] != 0) m |= (1 << k);
      return m;
   endfunction

   task automatic compare_regs(input string tag);
      check("R2", "sc_done", int'(sc_done), m_done);
      check("R2", "sc_data", int'(sc_data), m_data);
      check(tag, "resv_valid", int'(resv_valid), m_rv);
      check(tag, "resv_line", int'(resv_line), m_rl);
      check(tag, "resv_id", int'(resv_id), m_ri);
      check("R6", "lock_busy", int'(lock_busy), m_mask());
   endtask

   task automatic model_update(input int op, input int line, input int id, input int pres);
      int hit = 0;
      m_done = 0;
      m_data = 0;
      if (op == 4) begin
         m_rv = 1; m_rl = line; m_ri = id;
      end else if (op == 5) begin
         m_done = 1;
         m_data = (m_rv != 0 && m_rl == line && m_ri == id) ? 1 : 0;
         if (m_rv != 0 && m_rl == line) m_rv = 0;
      end else if (op == 3 || op == 6 || op == 7) begin
         if (pres != 0 && m_rv != 0 && m_rl == line && m_ri == id) m_rv = 0;
      end
      if (op == 6) begin
         for (int k = 0; k < NS; k++) if (m_busy[k] != 0 && m_sl[k] == line) hit = 1;
         if (hit == 0) begin
            for (int k = 0; k < NS; k++) begin
               if (m_busy[k] == 0 && hit == 0) begin
                  m_busy[k] = 1; m_sl[k] = line; hit = 1;
               end
            end
         end
      end else if (op == 7) begin
         for (int k = 0; k < NS; k++) if (m_busy[k] != 0 && m_sl[k] == line) m_busy[k] = 0;
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input int op, input int line, input int id, input int pres,
                       input int rv, input int rl, input string tag);
      int exp_stall = 0;
      cmp_valid   = (op != 0);
      cmp_op      = op[2:0];
      cmp_line    = line[LW-1:0];
      cmp_id      = id[IW-1:0];
      cmp_present = pres[0];
      req_valid   = rv[0];
      req_line    = rl[LW-1:0];
      #1;
      for (int k = 0; k < NS; k++) if (rv != 0 && m_busy[k] != 0 && m_sl[k] == rl) exp_stall = 1;
      check("R8", "req_stall", int'(req_stall), exp_stall);
      @(posedge clk);
      model_update(op, line, id, pres);
      @(negedge clk);
      compare_regs(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < NS; k++) begin m_busy[k] = 0; m_sl[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare_regs("R9");
      // R1 / R2 / R3: linked load then matching conditional store
      step(4, 10, 1, 1, 0, 0, "R1");
      step(5, 10, 1, 1, 0, 0, "R3");
      step(5, 10, 1, 1, 0, 0, "R3");      // no reservation: fails
      step(4, 10, 1, 1, 0, 0, "R1");
      step(5, 10, 2, 1, 0, 0, "R3");      // wrong ID: fails, still clears
      step(4, 10, 1, 1, 0, 0, "R1");
      step(5, 11, 1, 1, 0, 0, "R3");      // other line: fails, kept
      step(4, 20, 2, 1, 0, 0, "R1");      // replaces earlier
      step(5, 10, 1, 1, 0, 0, "R1");      // old reservation gone
      // R5: reads do not touch the reservation
      step(4, 30, 3, 1, 0, 0, "R1");
      step(1, 30, 3, 1, 0, 0, "R5");
      step(2, 30, 3, 1, 0, 0, "R5");
      step(0, 30, 3, 1, 0, 0, "R5");
      // R4: write-class clearing rules
      step(3, 30, 3, 0, 0, 0, "R4");      // absent line: kept
      step(3, 30, 5, 1, 0, 0, "R4");      // foreign ID: kept
      step(3, 31, 3, 1, 0, 0, "R4");      // other line: kept
      step(3, 30, 3, 1, 0, 0, "R4");      // clears
      step(5, 30, 3, 1, 0, 0, "R2");
      // R6 / R7 / R8: locked lines
      step(4, 40, 6, 1, 1, 40, "R1");
      step(6, 40, 6, 1, 1, 40, "R4");     // lock read clears own reservation
      step(0, 0, 0, 0, 1, 40, "R8");
      step(0, 0, 0, 0, 1, 41, "R8");
      step(0, 0, 0, 0, 0, 40, "R8");
      step(6, 40, 6, 1, 1, 40, "R6");     // already blocked
      step(6, 41, 7, 1, 1, 41, "R6");
      step(6, 42, 7, 1, 1, 42, "R6");     // table full
      step(7, 40, 6, 1, 1, 40, "R7");
      step(0, 0, 0, 0, 1, 40, "R7");
      step(6, 42, 7, 1, 1, 41, "R6");     // takes freed slot 0
      step(7, 43, 7, 1, 1, 42, "R7");     // not blocked: no change
      step(7, 41, 7, 1, 1, 41, "R7");
      step(7, 42, 7, 1, 1, 42, "R7");
      step(0, 0, 0, 0, 1, 42, "R8");
      // R2 after mixed traffic
      step(4, 50, 9, 1, 0, 0, "R1");
      step(5, 50, 9, 0, 0, 0, "R2");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule